// File: doc/BRIEF.md
# Outbound Address Window Translator

This block rewrites local bus addresses that fall inside a fixed 256 MB outbound window (local addresses 0x6000_0000 to 0x6FFF_FFFF) into 64-bit link-side addresses. The window is cut into 32 regions of equal size. Each region has a programmable base, made of an upper 32-bit word and a low base field, and its own enable bit. A run-time size code sets the region size to 1, 2, 4 or 8 MB. The size code moves two things together: the local address bits that select the region, and the number of low base bits that replace local address bits.

Configuration arrives through a single-cycle write port. A 7-bit selector chooses between the control word, a region's low base word and a region's high base word. Lookups are offered with a valid strobe. One cycle later the block returns the resulting 64-bit address, a hit flag when a translation took place, and an error pulse when the address landed in a region that is switched off. An address is passed through unchanged, zero-extended to 64 bits, when translation is off globally, when it lies outside the window, or when its region is disabled.

Top module: `ob_xlat`

## Requirements
- R1: After reset, `out_valid`, `out_hit`, `out_err` and `out_addr` are zero, global translation is off, the size code is 0, and every region is disabled.
- R2: `out_valid` equals `in_valid` of the previous cycle. `out_hit` and `out_err` are only ever high together with `out_valid`.
- R3: While global translation is off, a lookup gives `out_addr = {32'h0, in_addr}` with `out_hit = 0` and `out_err = 0`.
- R4: A lookup whose address bits [31:28] are not 4'h6 gives `{32'h0, in_addr}` with no hit and no error, whatever the configuration.
- R5: Size code c (0..3) selects the region with address bits [24+c:20+c]. Code 0 means 1 MB, 1 means 2 MB, 2 means 4 MB and 3 means 8 MB.
- R6: A lookup that hits returns `{hi_base, lo_base[31:20+c], in_addr[19+c:0]}` with `out_hit = 1` and `out_err = 0`. Low base bits [19+c:20] are ignored.
- R7: A windowed lookup into a disabled region, with translation on, gives `{32'h0, in_addr}`, `out_hit = 0` and a single-cycle `out_err = 1`.
- R8: The selector is `cfg_sel[6:5]` = kind and `cfg_sel[4:0]` = region. The kinds are:
  - Kind 0 is the control word: `cfg_wdata[0]` is the global enable and `cfg_wdata[5:4]` is the size code.
  - Kind 1 is the low base of a region: `cfg_wdata[31:20]` is the base and `cfg_wdata[0]` is the region enable.
  - Kind 2 is the high base of a region, all 32 bits.
  
  A write takes effect for lookups from the following cycle on.
- R9: A write with kind 3 changes no configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 7 | Kind [6:5] and region [4:0] of the write |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Lookup strobe |
| in_addr | input | 32 | Local address to translate |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_addr | output | 64 | Translated or passed-through address |
| out_hit | output | 1 | Translation applied |
| out_err | output | 1 | Lookup hit a disabled region |

## Verification
Every lookup result (`out_valid`, `out_addr`, `out_hit`, `out_err`) is due exactly one clock edge after the lookup is presented. A configuration write only affects lookups presented after the edge that captures it. The bench drives on the falling edge, so the rising edge between two falling edges captures the request. It then reads the result at the next falling edge and clears the strobe in that same step. One idle falling edge after an error lookup confirms that the error pulse has dropped. The same idle edge confirms that the valid flag follows the strobe.

// File: rtl/ob_xlat_pkg.sv
package ob_xlat_pkg;
    localparam int ADDR_W_D    = 32;
    localparam int NUM_REG_D   = 32;
    localparam int MIN_SHIFT_D = 20;
    localparam int SIZE_W_D    = 2;

    typedef enum logic [1:0] {
        KIND_CTRL   = 2'd0,
        KIND_LOBASE = 2'd1,
        KIND_HIBASE = 2'd2,
        KIND_NONE   = 2'd3
    } cfg_kind_e;
endpackage

// File: rtl/ob_xlat_cfg.sv
module ob_xlat_cfg
    import ob_xlat_pkg::*;
#(
    parameter int ADDR_W    = ADDR_W_D,
    parameter int NUM_REG   = NUM_REG_D,
    parameter int MIN_SHIFT = MIN_SHIFT_D,
    parameter int SIZE_W    = SIZE_W_D,
    localparam int IDX_W    = $clog2(NUM_REG),
    localparam int BASE_W   = ADDR_W - MIN_SHIFT
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_we,
    input  logic [IDX_W+1:0]                 cfg_sel,
    input  logic [ADDR_W-1:0]                cfg_wdata,
    output logic                             xlat_on,
    output logic [SIZE_W-1:0]                size_code,
    output logic [NUM_REG-1:0]               reg_en,
    output logic [NUM_REG-1:0][BASE_W-1:0]   reg_base,
    output logic [NUM_REG-1:0][ADDR_W-1:0]   reg_hi
);
    cfg_kind_e        kind;
    logic [IDX_W-1:0] widx;

    assign kind = cfg_kind_e'(cfg_sel[IDX_W+1:IDX_W]);
    assign widx = cfg_sel[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xlat_on   <= 1'b0;
            size_code <= '0;
        end else if (cfg_we && kind == KIND_CTRL) begin
            xlat_on   <= cfg_wdata[0];
            size_code <= cfg_wdata[4 +: SIZE_W];
        end
    end

    for (genvar g = 0; g < NUM_REG; g++) begin : g_region
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                reg_en[g]   <= 1'b0;
                reg_base[g] <= '0;
                reg_hi[g]   <= '0;
            end else if (cfg_we && widx == IDX_W'(g)) begin
                unique case (kind)
                    KIND_LOBASE: begin
                        reg_en[g]   <= cfg_wdata[0];
                        reg_base[g] <= cfg_wdata[ADDR_W-1:MIN_SHIFT];
                    end
                    KIND_HIBASE: reg_hi[g] <= cfg_wdata;
                    KIND_CTRL, KIND_NONE: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/ob_xlat_map.sv
module ob_xlat_map
#(
    parameter int          ADDR_W    = 32,
    parameter int          NUM_REG   = 32,
    parameter int          MIN_SHIFT = 20,
    parameter int          SIZE_W    = 2,
    parameter int          WIN_LSB   = 28,
    parameter logic [31:0] WIN_BASE  = 32'h6000_0000,
    localparam int IDX_W  = $clog2(NUM_REG),
    localparam int BASE_W = ADDR_W - MIN_SHIFT,
    localparam int XADDR_W = 2 * ADDR_W
) (
    input  logic [ADDR_W-1:0]                in_addr,
    input  logic                             xlat_on,
    input  logic [SIZE_W-1:0]                size_code,
    input  logic [NUM_REG-1:0]               reg_en,
    input  logic [NUM_REG-1:0][BASE_W-1:0]   reg_base,
    input  logic [NUM_REG-1:0][ADDR_W-1:0]   reg_hi,
    output logic [XADDR_W-1:0]               nxt_addr,
    output logic                             nxt_hit,
    output logic                             nxt_err
);
    logic [7:0]        shift;
    logic [IDX_W-1:0]  idx;
    logic              in_win;
    logic [ADDR_W-1:0] keep_mask;
    logic [ADDR_W-1:0] base_full;
    logic [ADDR_W-1:0] low_word;

    always_comb begin
        shift     = 8'(MIN_SHIFT) + 8'(size_code);
        idx       = IDX_W'(in_addr >> shift);
        in_win    = in_addr[ADDR_W-1:WIN_LSB] == WIN_BASE[ADDR_W-1:WIN_LSB];
        keep_mask = {ADDR_W{1'b1}} << shift;
        base_full = {reg_base[idx], {MIN_SHIFT{1'b0}}};
        low_word  = (base_full & keep_mask) | (in_addr & ~keep_mask);

        nxt_hit  = 1'b0;
        nxt_err  = 1'b0;
        nxt_addr = {{ADDR_W{1'b0}}, in_addr};
        if (xlat_on && in_win) begin
            if (reg_en[idx]) begin
                nxt_hit  = 1'b1;
                nxt_addr = {reg_hi[idx], low_word};
            end else begin
                nxt_err  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ob_xlat.sv
module ob_xlat
    import ob_xlat_pkg::*;
#(
    parameter int          ADDR_W    = ADDR_W_D,
    parameter int          NUM_REG   = NUM_REG_D,
    parameter int          MIN_SHIFT = MIN_SHIFT_D,
    parameter int          SIZE_W    = SIZE_W_D,
    parameter logic [31:0] WIN_BASE  = 32'h6000_0000,
    localparam int IDX_W   = $clog2(NUM_REG),
    localparam int BASE_W  = ADDR_W - MIN_SHIFT,
    localparam int XADDR_W = 2 * ADDR_W,
    localparam int WIN_LSB = MIN_SHIFT + IDX_W + (1 << SIZE_W) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [IDX_W+1:0]   cfg_sel,
    input  logic [ADDR_W-1:0]  cfg_wdata,
    input  logic               in_valid,
    input  logic [ADDR_W-1:0]  in_addr,
    output logic               out_valid,
    output logic [XADDR_W-1:0] out_addr,
    output logic               out_hit,
    output logic               out_err
);
    logic                           xlat_on;
    logic [SIZE_W-1:0]              size_code;
    logic [NUM_REG-1:0]             reg_en;
    logic [NUM_REG-1:0][BASE_W-1:0] reg_base;
    logic [NUM_REG-1:0][ADDR_W-1:0] reg_hi;
    logic [XADDR_W-1:0]             nxt_addr;
    logic                           nxt_hit;
    logic                           nxt_err;

    ob_xlat_cfg #(
        .ADDR_W(ADDR_W), .NUM_REG(NUM_REG),
        .MIN_SHIFT(MIN_SHIFT), .SIZE_W(SIZE_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .xlat_on(xlat_on), .size_code(size_code),
        .reg_en(reg_en), .reg_base(reg_base), .reg_hi(reg_hi)
    );

    ob_xlat_map #(
        .ADDR_W(ADDR_W), .NUM_REG(NUM_REG), .MIN_SHIFT(MIN_SHIFT),
        .SIZE_W(SIZE_W), .WIN_LSB(WIN_LSB), .WIN_BASE(WIN_BASE)
    ) u_map (
        .in_addr(in_addr), .xlat_on(xlat_on), .size_code(size_code),
        .reg_en(reg_en), .reg_base(reg_base), .reg_hi(reg_hi),
        .nxt_addr(nxt_addr), .nxt_hit(nxt_hit), .nxt_err(nxt_err)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_hit   <= 1'b0;
            out_err   <= 1'b0;
            out_addr  <= '0;
        end else begin
            out_valid <= in_valid;
            out_hit   <= in_valid && nxt_hit;
            out_err   <= in_valid && nxt_err;
            if (in_valid) begin
                out_addr <= nxt_addr;
            end
        end
    end
endmodule

// File: rtl/ob_xlat_chk.sv
module ob_xlat_chk #(
    parameter int          ADDR_W    = 32,
    parameter int          MIN_SHIFT = 20,
    parameter int          WIN_LSB   = 28,
    parameter logic [31:0] WIN_BASE  = 32'h6000_0000
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [ADDR_W-1:0]   in_addr,
    input logic                out_valid,
    input logic [2*ADDR_W-1:0] out_addr,
    input logic                out_hit,
    input logic                out_err
);
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_flags_need_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_hit || out_err) |-> out_valid);

    assert_outside_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_addr[ADDR_W-1:WIN_LSB] != WIN_BASE[ADDR_W-1:WIN_LSB])
        |=> (!out_hit && !out_err && out_addr == {{ADDR_W{1'b0}}, $past(in_addr)}));

    assert_hit_err_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_hit && out_err));

    assert_offset_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_hit |-> out_addr[MIN_SHIFT-1:0] == $past(in_addr[MIN_SHIFT-1:0]));

    assert_miss_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_hit) |-> out_addr[2*ADDR_W-1:ADDR_W] == '0);
endmodule

bind ob_xlat ob_xlat_chk #(
    .ADDR_W(ADDR_W), .MIN_SHIFT(MIN_SHIFT), .WIN_LSB(WIN_LSB), .WIN_BASE(WIN_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .out_valid(out_valid), .out_addr(out_addr), .out_hit(out_hit), .out_err(out_err)
);

// File: tb/sim_ob_xlat.sv
`timescale 1ns/100ps
module sim_ob_xlat;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic        out_valid;
    logic [63:0] out_addr;
    logic        out_hit;
    logic        out_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ob_xlat u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_addr(in_addr),
        .out_valid(out_valid), .out_addr(out_addr), .out_hit(out_hit), .out_err(out_err)
    );

    // {in_addr, expected out_addr, expected hit, expected err}, size code 0
    localparam logic [97:0] VEC [0:7] = '{
        {32'h6001_5678, 64'h0000_0000_9001_5678, 1'b1, 1'b0},
        {32'h6050_0ABC, 64'h0000_ABCD_1230_0ABC, 1'b1, 1'b0},
        {32'h61F1_2345, 64'h0000_0001_FFF1_2345, 1'b1, 1'b0},
        {32'h6020_0001, 64'h0000_0000_6020_0001, 1'b0, 1'b1},
        {32'h7000_0000, 64'h0000_0000_7000_0000, 1'b0, 1'b0},
        {32'h5FFF_FFFF, 64'h0000_0000_5FFF_FFFF, 1'b0, 1'b0},
        {32'h6FF0_0010, 64'h0000_0001_FFF0_0010, 1'b1, 1'b0},
        {32'h6030_0000, 64'h0000_0000_6030_0000, 1'b0, 1'b1}
    };
    localparam string VREQ [0:7] = '{"R6", "R5", "R5", "R7", "R4", "R4", "R5", "R7"};

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [1:0] kind, input logic [4:0] idx, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = {kind, idx}; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic lookup(input string req, input logic [31:0] a, input logic [63:0] ea,
                          input logic eh, input logic ee);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2", "valid", 64'(out_valid), 64'd1);
        check(req, "addr", out_addr, ea);
        check(req, "hit", 64'(out_hit), 64'(eh));
        check(req, "err", 64'(out_err), 64'(ee));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        check("R1", "valid", 64'(out_valid), 64'd0);
        check("R1", "hit", 64'(out_hit), 64'd0);
        check("R1", "err", 64'(out_err), 64'd0);
        check("R1", "addr", out_addr, 64'd0);
        rst_n = 1'b1;
        // R1: global off after reset -> pass-through
        lookup("R1", 32'h6001_5678, 64'h0000_0000_6001_5678, 1'b0, 1'b0);
        // R1: regions disabled after reset
        cfg_wr(2'd0, 5'd0, 32'h0000_0001);
        lookup("R1", 32'h6001_5678, 64'h0000_0000_6001_5678, 1'b0, 1'b1);

        // R8 configuration, R6 ignored low base bits (0x9000_0FF1)
        cfg_wr(2'd1, 5'd0,  32'h9000_0FF1);
        cfg_wr(2'd2, 5'd0,  32'h0000_0000);
        cfg_wr(2'd1, 5'd5,  32'h1230_0001);
        cfg_wr(2'd2, 5'd5,  32'h0000_ABCD);
        cfg_wr(2'd1, 5'd31, 32'hFFF0_0001);
        cfg_wr(2'd2, 5'd31, 32'h0000_0001);
        cfg_wr(2'd1, 5'd2,  32'h4560_0000);

        for (int i = 0; i < 8; i++) begin
            lookup(VREQ[i], VEC[i][97:66], VEC[i][65:2], VEC[i][1], VEC[i][0]);
        end

        // R7 single-cycle error pulse, R2 valid drops
        lookup("R7", 32'h6020_0001, 64'h0000_0000_6020_0001, 1'b0, 1'b1);
        @(negedge clk);
        check("R7", "err pulse end", 64'(out_err), 64'd0);
        check("R2", "valid idle", 64'(out_valid), 64'd0);

        // R5 size code 1: index bits [25:21]
        cfg_wr(2'd0, 5'd0, 32'h0000_0011);
        lookup("R5", 32'h60A1_2345, 64'h0000_ABCD_1221_2345, 1'b1, 1'b0);
        // R5 size code 2: index bits [26:22]
        cfg_wr(2'd0, 5'd0, 32'h0000_0021);
        lookup("R6", 32'h6000_1111, 64'h0000_0000_9000_1111, 1'b1, 1'b0);
        lookup("R5", 32'h6140_0000, 64'h0000_ABCD_1200_0000, 1'b1, 1'b0);
        // R5 size code 3: index bits [27:23]
        cfg_wr(2'd0, 5'd0, 32'h0000_0031);
        lookup("R5", 32'h6F81_0000, 64'h0000_0001_FF81_0000, 1'b1, 1'b0);

        // R3 global off
        cfg_wr(2'd0, 5'd0, 32'h0000_0030);
        lookup("R3", 32'h6001_5678, 64'h0000_0000_6001_5678, 1'b0, 1'b0);

        // R9 kind 3 write has no effect
        cfg_wr(2'd0, 5'd0, 32'h0000_0001);
        cfg_wr(2'd3, 5'd0, 32'h0000_0000);
        lookup("R9", 32'h6001_5678, 64'h0000_0000_9001_5678, 1'b1, 1'b0);

        // R8 region enable bit cleared by low base write
        cfg_wr(2'd1, 5'd0, 32'h9000_0000);
        lookup("R8", 32'h6001_5678, 64'h0000_0000_6001_5678, 1'b0, 1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule